// File: doc/BRIEF.md
# SPI Register Read Sequencer

This block is an SPI master that carries out one complete register read on a sensor-style slave. A single-cycle `start` with a 6-bit register address drives chip select low. The block then shifts out a command byte with the read flag set and throws away whatever the slave returns during that byte. After that it clocks out zero bytes to collect the reply. It releases chip select once the last byte is in, and only then does it publish the collected bytes with a one-cycle `done`.

The serial clock idles high. The master moves MOSI on falling edges and samples MISO on rising edges, with 8-bit frames sent MSB first. The SCK half period comes from the system clock through a programmable count. For example, `half_per = 9` gives a 4 MHz SCK from an 80 MHz system clock, which stays under a 5 MHz slave limit. A non-zero burst length turns on the multi-byte flag in the command and keeps chip select low for all the reply bytes.

Top module: `spi_rdseq`

## Requirements
- R1: After reset `cs_n` = 1, `sck` = 1, `mosi` = 0, `busy` = 0, `done` = 0 and `rd_data` = 0.
- R2: A `start` seen while idle drives `cs_n` low and `busy` high in the next cycle. The first SCK falling edge comes exactly `half_per`+1 clock cycles after `cs_n` falls, and `cs_n` stays low until the transfer ends.
- R3: The command byte sent on `mosi` MSB first is bit 7 = 1 (read), bit 6 = 1 exactly when `burst_len` is non-zero, and bits 5:0 = `addr`. Address 0x00 with `burst_len` = 0 therefore gives 0x80. `mosi` changes only on SCK falling edges.
- R4: While deselected, SCK idles high. Every SCK phase while selected lasts exactly `half_per`+1 clock cycles.
- R5: The byte received during the command byte never appears in `rd_data`.
- R6: During the reply bytes `mosi` is 0. MISO is sampled on rising edges, MSB first. Reply byte k goes to `rd_data[8k+7:8k]`, and byte lanes above `burst_len` read as 0.
- R7: One transfer has exactly 8·(`burst_len`+2) SCK rising edges.
- R8: The last SCK rising edge is followed by exactly `half_per`+1 clock cycles before `cs_n` rises, and SCK is high when `cs_n` rises.
- R9: `done` is a one-cycle pulse in the cycle after `cs_n` returns high. `busy` is low in that cycle, and `rd_data` changes only in that cycle.
- R10: A `start` made while `busy` is high is ignored. No extra transfer or `done` results from it.
- R11: `addr`, `burst_len` and `half_per` are captured when a transfer is accepted. Changing them during the transfer has no effect on its timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one read, taken only while idle |
| addr | input | 6 | Register address of the slave |
| burst_len | input | BURST_W | Number of reply bytes minus one |
| half_per | input | DIV_W | SCK half period in clock cycles minus one |
| busy | output | 1 | High from an accepted start to the done cycle |
| done | output | 1 | One-cycle pulse when `rd_data` is updated |
| rd_data | output | 8·2^BURST_W | Collected reply bytes, byte 0 in the low lane |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench builds the block with DIV_W = 4 and BURST_W = 2. That lets it reach both the slowest clock setting (`half_per` = 15) and the fastest (`half_per` = 0), and it lets it fill all four result lanes with a maximal burst. With these values, address wrap past 0x3F within a burst, a busy-time start combined with changed inputs, and back-to-back reads all fit in a few thousand cycles. A slave model returns a junk byte during the command and address-derived bytes afterwards, so a leaked command echo or a misplaced lane changes the result.

// File: rtl/spi_rdseq_pkg.sv
package spi_rdseq_pkg;

  localparam int unsigned FRAME_W = 8;
  localparam int unsigned ADDR_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_FIN
  } seq_st_e;

  // Command byte: read flag on top, multi-byte flag below it, then address (R3)
  function automatic logic [FRAME_W-1:0] build_cmd(input logic [ADDR_W-1:0] a,
                                                   input logic multi);
    return {1'b1, multi, a};
  endfunction

endpackage

// File: rtl/spi_rdseq_tick.sv
module spi_rdseq_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_q,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  // One tick every half_q+1 cycles while running (R4)
  assign tick = run && (cnt == half_q);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/spi_rdseq_shift.sv
module spi_rdseq_shift
  import spi_rdseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] cmd,
  input  logic               drive,
  input  logic               sample,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx_byte,
  output logic               byte_done
);

  localparam int unsigned BIT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] tx_sr;
  logic [FRAME_W-1:0] rx_sr;
  logic [BIT_W-1:0]   bit_idx;

  assign rx_byte = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr     <= '0;
      rx_sr     <= '0;
      bit_idx   <= '0;
      mosi      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        tx_sr   <= cmd;
        bit_idx <= '0;
        mosi    <= 1'b0;
      end
      // After the command has left, zeros remain: dummy bytes (R6)
      if (drive) begin
        mosi  <= tx_sr[FRAME_W-1];
        tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
      end
      if (sample) begin
        rx_sr   <= {rx_sr[FRAME_W-2:0], miso};
        bit_idx <= bit_idx + BIT_W'(1);
        if (bit_idx == BIT_W'(FRAME_W - 1)) byte_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_rdseq_collect.sv
module spi_rdseq_collect
  import spi_rdseq_pkg::*;
#(
  parameter int unsigned BURST_W = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 load,
  input  logic                                 byte_done,
  input  logic [FRAME_W-1:0]                   rx_byte,
  input  logic                                 commit,
  output logic [FRAME_W*(2**BURST_W)-1:0]      rd_data
);

  localparam int unsigned MAX_BYTES = 2 ** BURST_W;
  localparam int unsigned IDX_W     = BURST_W + 1;
  localparam int unsigned RES_W     = FRAME_W * MAX_BYTES;

  logic [IDX_W-1:0] idx;     // 0 is the command echo
  logic [RES_W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst || load)    idx <= '0;
    else if (byte_done) idx <= idx + IDX_W'(1);
  end

  // Staging lanes; index 0 never written so the command echo is dropped (R5)
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    logic [FRAME_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || load)                                   lane_q <= '0;
      else if (byte_done && (idx == IDX_W'(g + 1)))      lane_q <= rx_byte;
    end
    assign stage[g*FRAME_W +: FRAME_W] = lane_q;
  end

  // Result published only after chip select is released (R9)
  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (commit) rd_data <= stage;
  end

endmodule

// File: rtl/spi_rdseq_ctrl.sv
module spi_rdseq_ctrl
  import spi_rdseq_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned BURST_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BURST_W-1:0] burst_len,
  input  logic [DIV_W-1:0]   half_per,
  input  logic               tick,
  output logic [DIV_W-1:0]   half_q,
  output logic               run,
  output logic               load,
  output logic               drive,
  output logic               sample,
  output logic               commit,
  output logic               sck,
  output logic               cs_n,
  output logic               busy,
  output logic               done
);

  localparam int unsigned CNT_W = BURST_W + 5;

  seq_st_e          st;
  logic [CNT_W-1:0] bits_left;

  assign run    = (st == ST_LEAD) || (st == ST_LOW) || (st == ST_HIGH);
  assign load   = (st == ST_IDLE) && start;          // busy start ignored (R10)
  assign drive  = tick && ((st == ST_LEAD) || ((st == ST_HIGH) && (bits_left != '0)));
  assign sample = tick && (st == ST_LOW);
  assign commit = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sck       <= 1'b1;
      cs_n      <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      half_q    <= '0;
      bits_left <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          half_q    <= half_per;                     // R11
          bits_left <= (CNT_W'(burst_len) + CNT_W'(2)) << 3;   // R7
          cs_n      <= 1'b0;
          busy      <= 1'b1;
          st        <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin                     // lead guard (R2)
          sck <= 1'b0;
          st  <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sck       <= 1'b1;
          bits_left <= bits_left - CNT_W'(1);
          st        <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          if (bits_left == '0) begin                 // trail guard (R8)
            cs_n <= 1'b1;
            st   <= ST_FIN;
          end else begin
            sck <= 1'b0;
            st  <= ST_LOW;
          end
        end
        ST_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_rdseq.sv
module spi_rdseq
  import spi_rdseq_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned BURST_W = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [BURST_W-1:0]                burst_len,
  input  logic [DIV_W-1:0]                  half_per,
  output logic                              busy,
  output logic                              done,
  output logic [FRAME_W*(2**BURST_W)-1:0]   rd_data,
  output logic                              sck,
  output logic                              cs_n,
  output logic                              mosi,
  input  logic                              miso
);

  logic [DIV_W-1:0]   half_q;
  logic               run, tick, load, drive, sample, commit;
  logic               byte_done;
  logic [FRAME_W-1:0] rx_byte;
  logic [FRAME_W-1:0] cmd;

  assign cmd = build_cmd(addr, burst_len != '0);   // R3

  spi_rdseq_ctrl #(.DIV_W(DIV_W), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .burst_len(burst_len),
    .half_per(half_per), .tick(tick), .half_q(half_q), .run(run),
    .load(load), .drive(drive), .sample(sample), .commit(commit),
    .sck(sck), .cs_n(cs_n), .busy(busy), .done(done)
  );

  spi_rdseq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .half_q(half_q), .tick(tick)
  );

  spi_rdseq_shift u_shift (
    .clk(clk), .rst(rst), .load(load), .cmd(cmd), .drive(drive),
    .sample(sample), .miso(miso), .mosi(mosi), .rx_byte(rx_byte),
    .byte_done(byte_done)
  );

  spi_rdseq_collect #(.BURST_W(BURST_W)) u_collect (
    .clk(clk), .rst(rst), .load(load), .byte_done(byte_done),
    .rx_byte(rx_byte), .commit(commit), .rd_data(rd_data)
  );

endmodule

// File: rtl/spi_rdseq_chk.sv
module spi_rdseq_chk #(
  parameter int unsigned BURST_W = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic [8*(2**BURST_W)-1:0]  rd_data,
  input logic                       sck,
  input logic                       cs_n,
  input logic                       mosi
);

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) cs_n |-> sck); // R4
  AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (rst) !cs_n |-> busy); // R2
  AST_BUSY_SELECTS: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $fell(cs_n)); // R2
  AST_MOSI_HOLD_RISE: assert property (@(posedge clk) disable iff (rst) $rose(sck) |-> $stable(mosi)); // R3
  AST_RELEASE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> sck); // R8
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |=> done); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && cs_n)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(rd_data)); // R9
  AST_BUSY_START_KEEPS: assert property (@(posedge clk) disable iff (rst) (start && !cs_n) |=> !$rose(busy)); // R10

endmodule

bind spi_rdseq spi_rdseq_chk #(.BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .rd_data(rd_data), .sck(sck), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/sim_spi_rdseq.sv
module sim_spi_rdseq;

  localparam int unsigned DIV_W   = 4;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned RES_W   = 8 * (2 ** BURST_W);

  typedef struct {
    logic [RES_W-1:0] data;
    logic [7:0]       cmd;
    int               gap;
    int               rises;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic miso = 1'b0;
  logic [5:0] addr = '0;
  logic [BURST_W-1:0] burst = '0;
  logic [DIV_W-1:0] half = '0;
  logic busy, done, sck, cs_n, mosi;
  logic [RES_W-1:0] rd_data;

  always #4 clk = ~clk;   // 125 MHz

  spi_rdseq #(.DIV_W(DIV_W), .BURST_W(BURST_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .burst_len(burst),
    .half_per(half), .busy(busy), .done(done), .rd_data(rd_data),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails  = 0;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] slave_reg(input logic [5:0] a);
    return (8'(a) * 8'd29) ^ 8'h5A;
  endfunction

  // Slave model: mode 3, junk byte during the command
  int s_fall, s_rise, s_ones;
  logic [7:0] s_cmd;

  function automatic logic slave_bit(input int n);
    int byt;
    logic [7:0] v;
    byt = n / 8;
    v = (byt == 0) ? 8'h3C : slave_reg(s_cmd[5:0] + 6'(byt - 1));
    return v[7 - (n % 8)];
  endfunction

  always @(negedge cs_n) begin
    s_fall = 0; s_rise = 0; s_cmd = '0; s_ones = 0;
  end
  always @(posedge sck) if (cs_n === 1'b0) begin
    if (s_rise < 8) s_cmd = {s_cmd[6:0], mosi};
    else if (mosi) s_ones++;
    s_rise++;
  end
  always @(negedge sck) if (cs_n === 1'b0) begin
    miso = slave_bit(s_fall);
    s_fall++;
  end

  // Monitor
  int cyc = 0, last_evt = 0, gap_bad = 0, hold_bad = 0, done_cnt = 0;
  logic prev_cs = 1'b1, prev_sck = 1'b1, prev_done = 1'b0, in_txn = 1'b0;
  logic [RES_W-1:0] last_rd = '0;
  exp_t m_e;

  always @(negedge clk) if (!rst) begin
    cyc++;
    if (cs_n !== prev_cs || sck !== prev_sck) begin
      if (in_txn && sb_q.size() > 0 && (cyc - last_evt) != sb_q[0].gap) gap_bad++;
      if (prev_cs && !cs_n) in_txn = 1'b1;
      if (!prev_cs && cs_n) in_txn = 1'b0;
      last_evt = cyc;
    end
    if (prev_done) chk(!done, "R9 done pulse width", done, 0);
    if (done) begin
      done_cnt++;
      if (sb_q.size() == 0) chk(1'b0, "R10 unexpected done", done_cnt, 0);
      else begin
        m_e = sb_q.pop_front();
        chk(rd_data == m_e.data, "R5 R6 result", rd_data, m_e.data);
        chk(s_cmd == m_e.cmd, "R3 command byte", s_cmd, m_e.cmd);
        chk(s_ones == 0, "R6 dummy bytes zero", s_ones, 0);
        chk(gap_bad == 0, "R2 R4 R8 phase lengths", gap_bad, 0);
        chk(s_rise == m_e.rises, "R7 rising edges", s_rise, m_e.rises);
        chk(!busy && cs_n, "R9 idle at done", {busy, cs_n}, 2'b01);
        chk(hold_bad == 0, "R9 result held", hold_bad, 0);
      end
      gap_bad = 0;
      hold_bad = 0;
    end else if (rd_data !== last_rd) hold_bad++;
    prev_done = done; last_rd = rd_data; prev_cs = cs_n; prev_sck = sck;
  end

  // Driver
  task automatic do_read(input logic [5:0] a, input logic [BURST_W-1:0] b,
                         input logic [DIV_W-1:0] h, input bit disturb);
    exp_t e;
    int target;
    while (busy) @(negedge clk);
    e.cmd = {1'b1, (b != '0), a};
    e.gap = int'(h) + 1;
    e.rises = 8 * (int'(b) + 2);
    e.data = '0;
    for (int k = 0; k <= int'(b); k++) e.data[8*k +: 8] = slave_reg(a + 6'(k));
    sb_q.push_back(e);
    target = done_cnt + 1;
    addr = a; burst = b; half = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R2 select on start", {cs_n, busy}, 2'b01);
    if (disturb) begin
      repeat (3 * (int'(h) + 1) + 2) @(negedge clk);
      addr = ~a; burst = ~b; half = '0; start = 1'b1;   // R10 R11
      @(negedge clk);
      start = 1'b0;
      chk(!cs_n && busy, "R10 transfer continues", {cs_n, busy}, 2'b01);
    end
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && sck && !mosi, "R1 idle lines", {cs_n, sck, mosi}, 3'b110);
    chk(!busy && !done, "R1 idle flags", {busy, done}, 2'b00);
    chk(rd_data == '0, "R1 result cleared", rd_data, 0);
    do_read(6'h00, 2'd0, 4'd9, 1'b0);    // 0x80 command
    do_read(6'h3F, 2'd0, 4'd0, 1'b0);    // fastest clock
    do_read(6'h32, 2'd3, 4'd1, 1'b0);    // full burst
    do_read(6'h3E, 2'd2, 4'd15, 1'b1);   // slowest clock, wrap, busy start (R11)
    do_read(6'h15, 2'd1, 4'd3, 1'b0);
    repeat (40) @(negedge clk);
    chk(done_cnt == 5, "R10 done count", done_cnt, 5);
    chk(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule